// File: doc/BRIEF.md
# Transactional Line Store

This block is a small fully associative store that sits next to a processor's primary data cache and holds the speculative state of one transaction. A transaction controller sends it one command at a time: look up a line, allocate a line for transactional use, store into the speculative copy of a line, commit, or abort. Each entry holds a tag, one data word, a dirty flag and one of four states. The states are empty, normal, old-image (the value from before the transaction) and new-image (the speculative value).

Allocating an address for a transaction produces a pair of entries. One entry keeps the pre-transaction image and the other receives the speculative writes. Commit and abort each rewrite the states of all entries in a single clock. When a new entry is needed, the store picks a victim by state priority. If that victim is dirty, it is first sent out on a writeback port that uses a valid/ready handshake. When there are too few replaceable entries, the store reports an overflow and aborts the transaction itself.

Top module: `txline_store`

## Requirements
- R1: After reset every entry is empty: `cmdReady` is 1, `wbValid` and `rspValid` are 0, and every lookup misses with `rspState` 0.
- R2: Line states are encoded as 0 empty, 1 normal, 2 old-image, 3 new-image. Commands are encoded on `cmdOp` as 0 lookup, 1 allocate, 2 update, 3 commit, 4 abort. A lookup accepted on one edge gives `rspValid` on the next edge. For a hit, the response carries the state, data and dirty flag of the matching entry. A new-image entry is returned before a normal entry, and a normal entry before an old-image entry.
- R3: An allocate whose tag has no entry fills an old-image entry and then a new-image entry, both holding `cmdData` and both clean. An allocate whose tag holds a normal entry turns that entry into the old-image entry and fills one new-image entry with its data and dirty flag. The response reports state 3 with the new-image data.
- R4: An update whose tag has a new-image entry writes `cmdData` into it, sets its dirty flag and responds with a hit. An update without such an entry misses and changes nothing.
- R5: A commit, in one clock, empties every old-image entry and turns every new-image entry into a normal entry that keeps its data and dirty flag.
- R6: An abort, in one clock, empties every new-image entry and turns every old-image entry into a normal entry that keeps its data and dirty flag.
- R7: A victim is picked as the lowest-indexed empty entry. If there is none, the lowest-indexed normal entry is picked, and after that the lowest-indexed old-image entry. New-image entries and entries of the tag being allocated are never picked.
- R8: A dirty victim is offered on `wbValid` with its tag and data before it is reused. The offer stays stable until `wbReady` accepts it, and `cmdReady` stays 0 for the whole time.
- R9: If fewer replaceable entries are present than the allocate needs, the response has `rspOverflow` 1 and `rspHit` 0, and the store applies the abort of R6 in the same clock.
- R10: An allocate whose tag already holds a new-image entry responds with a hit on that entry and creates no new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Store can accept a command |
| cmdOp | input | 3 | Command code |
| cmdTag | input | TAG_W | Line address tag |
| cmdData | input | DATA_W | Old line data for allocate, store data for update |
| rspValid | output | 1 | Response present for one cycle |
| rspHit | output | 1 | Matching entry found or created |
| rspOverflow | output | 1 | Allocate overflowed; transaction aborted |
| rspState | output | 2 | State of the returned entry |
| rspData | output | DATA_W | Data of the returned entry |
| rspDirty | output | 1 | Dirty flag of the returned entry |
| wbValid | output | 1 | Dirty victim offered for writeback |
| wbReady | input | 1 | Writeback accepted |
| wbTag | output | TAG_W | Tag of the offered victim |
| wbData | output | DATA_W | Data of the offered victim |

## Verification
Lookup, update, commit, abort and an allocate that hits or overflows all respond one edge after acceptance. A filling allocate responds one edge after its last fill, and each fill takes one edge, or more when it waits for a writeback. After driving a command, the bench samples on every falling edge until `rspValid` appears, and it drives `wbReady` on falling edges at random. A handshake is counted only on the falling edge that follows the rising edge where it took place. Each response and each offered victim is compared with a bench model of the entry states. That model is updated per command from the rules in the requirements.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [1:0] {
    LS_EMPTY   = 2'd0,
    LS_NORMAL  = 2'd1,
    LS_XCOMMIT = 2'd2,
    LS_XABORT  = 2'd3
  } lineState_t;

  localparam logic [2:0] OP_LOOKUP = 3'd0;
  localparam logic [2:0] OP_TALLOC = 3'd1;
  localparam logic [2:0] OP_UPDATE = 3'd2;
  localparam logic [2:0] OP_COMMIT = 3'd3;
  localparam logic [2:0] OP_ABORT  = 3'd4;

  typedef struct packed {
    logic doCommit;
    logic doAbort;
    logic doUpdate;
    logic doConvert;
    logic doFill;
    logic fillXabort;
  } txStrobe_t;
endpackage

// File: rtl/txline_array.sv
module txline_array
  import txs_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 29,
  parameter int DATA_W  = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  txStrobe_t                     stb,
  input  logic [TAG_W-1:0]              keyTag,
  input  logic [DATA_W-1:0]             wrData,
  input  logic                          fillDirty,
  output logic                          hitAny,
  output logic                          hitXabort,
  output logic                          hitNormal,
  output lineState_t                    hitState,
  output logic [DATA_W-1:0]             hitData,
  output logic                          hitDirty,
  output logic [$clog2(ENTRIES+1)-1:0]  availCount,
  output logic                          victimDirty,
  output logic [TAG_W-1:0]              victimTag,
  output logic [DATA_W-1:0]             victimData
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(ENTRIES+1);

  lineState_t         stArr   [ENTRIES];
  logic [TAG_W-1:0]   tagArr  [ENTRIES];
  logic [DATA_W-1:0]  dataArr [ENTRIES];
  logic [ENTRIES-1:0] dirtyVec;

  logic [ENTRIES-1:0] matchVec, xabHit, normHit, xcoHit;
  logic [ENTRIES-1:0] candE, candN, candX, isXab, isXco;
  logic [IDX_W-1:0]   selIdx, victimIdx;

  function automatic logic [IDX_W-1:0] firstIdx(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      matchVec[e] = (stArr[e] != LS_EMPTY) && (tagArr[e] == keyTag);
      isXab[e]    = (stArr[e] == LS_XABORT);
      isXco[e]    = (stArr[e] == LS_XCOMMIT);
      xabHit[e]   = matchVec[e] && isXab[e];
      normHit[e]  = matchVec[e] && (stArr[e] == LS_NORMAL);
      xcoHit[e]   = matchVec[e] && isXco[e];
      candE[e]    = (stArr[e] == LS_EMPTY);
      candN[e]    = (stArr[e] == LS_NORMAL) && !matchVec[e];
      candX[e]    = isXco[e] && !matchVec[e];
    end
  end

  // lookup selection: new image, then normal, then old image
  always_comb begin
    hitXabort = |xabHit;
    hitNormal = |normHit;
    hitAny    = |matchVec;
    if (hitXabort)      selIdx = firstIdx(xabHit);
    else if (hitNormal) selIdx = firstIdx(normHit);
    else                selIdx = firstIdx(xcoHit);
    hitState = hitAny ? stArr[selIdx] : LS_EMPTY;
    hitData  = hitAny ? dataArr[selIdx] : '0;
    hitDirty = hitAny && dirtyVec[selIdx];
  end

  // victim selection by state priority
  always_comb begin
    if (|candE)      victimIdx = firstIdx(candE);
    else if (|candN) victimIdx = firstIdx(candN);
    else             victimIdx = firstIdx(candX);
    victimDirty = (|(candE | candN | candX)) && dirtyVec[victimIdx];
    victimTag   = tagArr[victimIdx];
    victimData  = dataArr[victimIdx];
    availCount  = CNT_W'($countones(candE | candN | candX));
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    logic fillHere;
    assign fillHere = stb.doFill && (victimIdx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stArr[e]    <= LS_EMPTY;
        tagArr[e]   <= '0;
        dataArr[e]  <= '0;
        dirtyVec[e] <= 1'b0;
      end else if (stb.doCommit) begin
        if (stArr[e] == LS_XCOMMIT) begin
          stArr[e]    <= LS_EMPTY;
          dirtyVec[e] <= 1'b0;
        end else if (stArr[e] == LS_XABORT) begin
          stArr[e] <= LS_NORMAL;
        end
      end else if (stb.doAbort) begin
        if (stArr[e] == LS_XABORT) begin
          stArr[e]    <= LS_EMPTY;
          dirtyVec[e] <= 1'b0;
        end else if (stArr[e] == LS_XCOMMIT) begin
          stArr[e] <= LS_NORMAL;
        end
      end else if (stb.doUpdate && xabHit[e]) begin
        dataArr[e]  <= wrData;
        dirtyVec[e] <= 1'b1;
      end else if (stb.doConvert && normHit[e]) begin
        stArr[e] <= LS_XCOMMIT;
      end else if (fillHere) begin
        stArr[e]    <= stb.fillXabort ? LS_XABORT : LS_XCOMMIT;
        tagArr[e]   <= keyTag;
        dataArr[e]  <= wrData;
        dirtyVec[e] <= stb.fillXabort && fillDirty;
      end
    end
  end

  assert_commit_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.doCommit |=> (isXco == '0));
  assert_abort_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.doAbort |=> (isXab == '0));
  assert_xabort_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.doAbort && !stb.doCommit) |=> ($countones(isXab) >= $past($countones(isXab))));
  assert_single_xabort_R10: assert property (@(posedge clk) disable iff (!rstN)
    $countones(xabHit) <= 1);
endmodule

// File: rtl/txline_ctrl.sv
module txline_ctrl
  import txs_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 29,
  parameter int DATA_W  = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdValid,
  input  logic [2:0]                    cmdOp,
  input  logic [TAG_W-1:0]              cmdTag,
  input  logic [DATA_W-1:0]             cmdData,
  output logic                          cmdReady,
  input  logic                          hitAny,
  input  logic                          hitXabort,
  input  logic                          hitNormal,
  input  lineState_t                    hitState,
  input  logic [DATA_W-1:0]             hitData,
  input  logic                          hitDirty,
  input  logic [$clog2(ENTRIES+1)-1:0]  availCount,
  input  logic                          victimDirty,
  output txStrobe_t                     stb,
  output logic [TAG_W-1:0]              keyTag,
  output logic [DATA_W-1:0]             wrData,
  output logic                          fillDirty,
  output logic                          wbValid,
  input  logic                          wbReady,
  output logic                          rspValid,
  output logic                          rspHit,
  output logic                          rspOverflow,
  output lineState_t                    rspState,
  output logic [DATA_W-1:0]             rspData,
  output logic                          rspDirty
);
  localparam int CNT_W = $clog2(ENTRIES+1);

  typedef enum logic {ST_IDLE, ST_ALLOC} ctlState_t;
  ctlState_t         ctlState;
  logic              pendXcommit;
  logic [TAG_W-1:0]  savedTag;
  logic [DATA_W-1:0] savedData;
  logic              savedDirty;

  logic accept, isTalloc, tallocOvf, tallocGo;
  logic [CNT_W-1:0] needCount;

  assign cmdReady  = (ctlState == ST_IDLE);
  assign accept    = cmdReady && cmdValid;
  assign isTalloc  = (cmdOp == OP_TALLOC);
  assign needCount = hitNormal ? CNT_W'(1) : CNT_W'(2);
  assign tallocOvf = !hitXabort && (availCount < needCount);
  assign tallocGo  = accept && isTalloc && !hitXabort && !tallocOvf;

  assign keyTag    = cmdReady ? cmdTag  : savedTag;
  assign wrData    = cmdReady ? cmdData : savedData;
  assign fillDirty = savedDirty;
  assign wbValid   = (ctlState == ST_ALLOC) && victimDirty;

  always_comb begin
    stb            = '0;
    stb.doUpdate   = accept && (cmdOp == OP_UPDATE);
    stb.doCommit   = accept && (cmdOp == OP_COMMIT);
    stb.doAbort    = accept && ((cmdOp == OP_ABORT) || (isTalloc && tallocOvf));
    stb.doConvert  = tallocGo && hitNormal;
    stb.doFill     = (ctlState == ST_ALLOC) && (!victimDirty || wbReady);
    stb.fillXabort = !pendXcommit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlState    <= ST_IDLE;
      pendXcommit <= 1'b0;
      savedTag    <= '0;
      savedData   <= '0;
      savedDirty  <= 1'b0;
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspOverflow <= 1'b0;
      rspState    <= LS_EMPTY;
      rspData     <= '0;
      rspDirty    <= 1'b0;
    end else begin
      rspValid    <= 1'b0;
      rspOverflow <= 1'b0;
      if (ctlState == ST_IDLE) begin
        if (tallocGo) begin
          ctlState    <= ST_ALLOC;
          pendXcommit <= !hitNormal;
          savedTag    <= cmdTag;
          savedData   <= hitNormal ? hitData : cmdData;
          savedDirty  <= hitNormal && hitDirty;
        end else if (accept) begin
          rspValid <= 1'b1;
          rspHit   <= 1'b0;
          rspState <= LS_EMPTY;
          rspData  <= '0;
          rspDirty <= 1'b0;
          if (cmdOp == OP_LOOKUP || (isTalloc && hitXabort)) begin
            rspHit   <= hitAny;
            rspState <= hitState;
            rspData  <= hitData;
            rspDirty <= hitDirty;
          end else if (isTalloc) begin
            rspOverflow <= 1'b1;
          end else if (cmdOp == OP_UPDATE && hitXabort) begin
            rspHit   <= 1'b1;
            rspState <= LS_XABORT;
            rspData  <= cmdData;
            rspDirty <= 1'b1;
          end
        end
      end else if (stb.doFill) begin
        if (pendXcommit) begin
          pendXcommit <= 1'b0;
        end else begin
          ctlState    <= ST_IDLE;
          rspValid    <= 1'b1;
          rspHit      <= 1'b1;
          rspState    <= LS_XABORT;
          rspData     <= savedData;
          rspDirty    <= savedDirty;
        end
      end
    end
  end

  assert_rsp_next_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp == OP_LOOKUP) |=> rspValid);
  assert_wb_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady) |=> (wbValid && $stable(savedTag)));
  assert_ready_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !cmdReady);
  assert_overflow_miss_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOverflow) |-> !rspHit);
endmodule

// File: rtl/txline_store.sv
module txline_store
  import txs_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 29,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [TAG_W-1:0]  cmdTag,
  input  logic [DATA_W-1:0] cmdData,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspOverflow,
  output logic [1:0]        rspState,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDirty,
  output logic              wbValid,
  input  logic              wbReady,
  output logic [TAG_W-1:0]  wbTag,
  output logic [DATA_W-1:0] wbData
);
  localparam int CNT_W = $clog2(ENTRIES+1);

  txStrobe_t          stb;
  logic [TAG_W-1:0]   keyTag;
  logic [DATA_W-1:0]  wrData, hitData;
  logic               fillDirty, hitAny, hitXabort, hitNormal, hitDirty, victimDirty;
  lineState_t         hitState, rspStateE;
  logic [CNT_W-1:0]   availCount;

  txline_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) uArray (
    .clk(clk), .rstN(rstN), .stb(stb), .keyTag(keyTag), .wrData(wrData),
    .fillDirty(fillDirty), .hitAny(hitAny), .hitXabort(hitXabort),
    .hitNormal(hitNormal), .hitState(hitState), .hitData(hitData),
    .hitDirty(hitDirty), .availCount(availCount), .victimDirty(victimDirty),
    .victimTag(wbTag), .victimData(wbData)
  );

  txline_ctrl #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdTag(cmdTag),
    .cmdData(cmdData), .cmdReady(cmdReady), .hitAny(hitAny), .hitXabort(hitXabort),
    .hitNormal(hitNormal), .hitState(hitState), .hitData(hitData),
    .hitDirty(hitDirty), .availCount(availCount), .victimDirty(victimDirty),
    .stb(stb), .keyTag(keyTag), .wrData(wrData), .fillDirty(fillDirty),
    .wbValid(wbValid), .wbReady(wbReady), .rspValid(rspValid), .rspHit(rspHit),
    .rspOverflow(rspOverflow), .rspState(rspStateE), .rspData(rspData),
    .rspDirty(rspDirty)
  );

  assign rspState = rspStateE;
endmodule

// File: tb/txline_store_test.sv
module txline_store_test;
  localparam int ENT = 8;
  logic clk = 0, rstN = 0;
  logic cmdValid = 0, cmdReady, wbReady = 0;
  logic [2:0] cmdOp = 0;
  logic [7:0] cmdTag = 0;
  logic [63:0] cmdData = 0, rspData, wbData;
  logic rspValid, rspHit, rspOverflow, rspDirty, wbValid;
  logic [1:0] rspState;
  logic [7:0] wbTag;
  int checks = 0, failures = 0;

  int mSt [ENT];
  int mTag [ENT];
  logic [63:0] mData [ENT];
  bit mDirty [ENT];
  int wbT [2];
  logic [63:0] wbD [2];
  int wbN;

  always #5 clk = ~clk;

  txline_store #(.ENTRIES(ENT), .TAG_W(8), .DATA_W(64)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdTag(cmdTag), .cmdData(cmdData), .rspValid(rspValid), .rspHit(rspHit),
    .rspOverflow(rspOverflow), .rspState(rspState), .rspData(rspData),
    .rspDirty(rspDirty), .wbValid(wbValid), .wbReady(wbReady), .wbTag(wbTag),
    .wbData(wbData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int mFind(int tag, int st);
    for (int i = 0; i < ENT; i++) if (mSt[i] == st && mTag[i] == tag) return i;
    return -1;
  endfunction

  function automatic bit mProt(int i, int tag);
    return mSt[i] != 0 && mTag[i] == tag;
  endfunction

  function automatic int mVictim(int tag);
    for (int pr = 0; pr < 3; pr++)
      for (int i = 0; i < ENT; i++) if (mSt[i] == pr && !mProt(i, tag)) return i;
    return -1;
  endfunction

  function automatic int mAvail(int tag);
    int n = 0;
    for (int i = 0; i < ENT; i++) if (mSt[i] != 3 && !mProt(i, tag)) n++;
    return n;
  endfunction

  function automatic int mLook(int tag);
    int r = mFind(tag, 3);
    if (r < 0) r = mFind(tag, 1);
    if (r < 0) r = mFind(tag, 2);
    return r;
  endfunction

  function automatic void mAbort();
    for (int i = 0; i < ENT; i++)
      if (mSt[i] == 3) begin mSt[i] = 0; mDirty[i] = 0; end
      else if (mSt[i] == 2) mSt[i] = 1;
  endfunction

  function automatic void mCommit();
    for (int i = 0; i < ENT; i++)
      if (mSt[i] == 2) begin mSt[i] = 0; mDirty[i] = 0; end
      else if (mSt[i] == 3) mSt[i] = 1;
  endfunction

  function automatic void mFill(int tag, logic [63:0] d, int st, bit dty);
    int v = mVictim(tag);
    if (mDirty[v]) begin wbT[wbN] = mTag[v]; wbD[wbN] = mData[v]; wbN++; end
    mSt[v] = st; mTag[v] = tag; mData[v] = d; mDirty[v] = dty;
  endfunction

  task automatic runCmd(input int op, input int tag, input logic [63:0] data, input string req);
    bit eHit = 0, eOvf = 0, eDty = 0, done = 0, prevHs = 0;
    int eSt = 0, wbSeen = 0, ix, no;
    logic [63:0] eData = 0;
    wbN = 0;
    case (op)
      0: begin
        ix = mLook(tag);
        if (ix >= 0) begin eHit = 1; eSt = mSt[ix]; eData = mData[ix]; eDty = mDirty[ix]; end
      end
      1: begin
        ix = mFind(tag, 3);
        no = mFind(tag, 1);
        if (ix >= 0) begin eHit = 1; eSt = 3; eData = mData[ix]; eDty = mDirty[ix]; end
        else if (mAvail(tag) < ((no >= 0) ? 1 : 2)) begin eOvf = 1; mAbort(); end
        else begin
          eHit = 1; eSt = 3;
          if (no >= 0) begin mSt[no] = 2; eData = mData[no]; eDty = mDirty[no]; end
          else begin eData = data; eDty = 0; mFill(tag, data, 2, 0); end
          mFill(tag, eData, 3, eDty);
        end
      end
      2: begin
        ix = mFind(tag, 3);
        if (ix >= 0) begin
          mData[ix] = data; mDirty[ix] = 1; eHit = 1; eSt = 3; eData = data; eDty = 1;
        end
      end
      3: mCommit();
      default: mAbort();
    endcase
    @(negedge clk);
    cmdValid = 1; cmdOp = op[2:0]; cmdTag = tag[7:0]; cmdData = data;
    @(negedge clk);
    cmdValid = 0;
    for (int k = 0; k < 300 && !done; k++) begin
      if (k > 0) @(negedge clk);
      if (prevHs) wbSeen++;
      prevHs = 0;
      if (wbValid) begin
        chk(cmdReady == 0, "R8", "cmdReady during writeback", 64'(cmdReady), 0);
        if (wbSeen < wbN) begin
          chk(wbTag == wbT[wbSeen][7:0], "R7", "victim tag", 64'(wbTag), 64'(wbT[wbSeen]));
          chk(wbData == wbD[wbSeen], "R8", "victim data", wbData, wbD[wbSeen]);
        end else chk(0, "R8", "unexpected writeback tag", 64'(wbTag), 0);
        wbReady = ($urandom % 3) != 0;
        prevHs = wbReady;
      end else wbReady = 0;
      if (rspValid) begin
        done = 1;
        chk(rspOverflow == eOvf, (eOvf ? "R9" : req), "overflow flag", 64'(rspOverflow), 64'(eOvf));
        if (op <= 2) begin
          chk(rspHit == eHit, req, "hit", 64'(rspHit), 64'(eHit));
          if (eHit) begin
            chk(rspState == eSt[1:0], req, "state", 64'(rspState), 64'(eSt));
            chk(rspData == eData, req, "data", rspData, eData);
            chk(rspDirty == eDty, req, "dirty", 64'(rspDirty), 64'(eDty));
          end
        end
      end
    end
    wbReady = 0;
    chk(done, req, "response arrived", 64'(done), 1);
    chk(wbSeen == wbN, "R8", "writeback count", 64'(wbSeen), 64'(wbN));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r, tg;
    void'($urandom(32'd1234));
    for (int i = 0; i < ENT; i++) begin mSt[i] = 0; mTag[i] = 0; mData[i] = 0; mDirty[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(cmdReady == 1, "R1", "cmdReady after reset", 64'(cmdReady), 1);
    chk(wbValid == 0, "R1", "wbValid after reset", 64'(wbValid), 0);
    chk(rspValid == 0, "R1", "rspValid after reset", 64'(rspValid), 0);
    runCmd(0, 3, 0, "R1");
    runCmd(1, 1, 64'hA1, "R3");
    runCmd(0, 1, 0, "R2");
    runCmd(2, 1, 64'hB2, "R4");
    runCmd(2, 9, 64'hCC, "R4");
    runCmd(0, 9, 0, "R4");
    runCmd(3, 0, 0, "R5");
    runCmd(0, 1, 0, "R5");
    runCmd(1, 1, 64'hEE, "R3");
    runCmd(4, 0, 0, "R6");
    runCmd(0, 1, 0, "R6");
    runCmd(1, 1, 64'h11, "R3");
    runCmd(1, 1, 64'h22, "R10");
    runCmd(1, 2, 64'h33, "R3");
    runCmd(1, 3, 64'h44, "R3");
    runCmd(1, 4, 64'h55, "R7");
    runCmd(1, 5, 64'h66, "R9");
    runCmd(0, 2, 0, "R9");
    for (int n = 0; n < 700; n++) begin
      r = $urandom % 100;
      tg = $urandom % 12;
      if (r < 30)      runCmd(0, tg, 0, "R2");
      else if (r < 60) runCmd(1, tg, {$urandom, $urandom}, "R3");
      else if (r < 82) runCmd(2, tg, {$urandom, $urandom}, "R4");
      else if (r < 92) begin runCmd(3, 0, 0, "R5"); runCmd(0, $urandom % 12, 0, "R5"); end
      else             begin runCmd(4, 0, 0, "R6"); runCmd(0, $urandom % 12, 0, "R6"); end
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule